// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Logic

This block holds the hazard decisions for an in-order integer pipeline with fetch, decode, execute, memory and write-back stages. Results reach the register file only in write-back. Each cycle the block looks at three things: the source register indices of the instruction in decode, the source indices of the instruction in execute, and the destination, write-enable and load flag of the older instructions held in the pipeline latches. From these it produces two outputs. The first is a 2-bit select for each execute-stage operand multiplexer, which picks the register file value, the execute-to-memory latch, or the memory-to-write-back latch. The second is one interlock signal.

When the interlock is high, the surrounding pipeline holds the program counter and the fetch/decode latch for one cycle and loads a bubble (all control bits zero) into the decode/execute latch. An ALU result feeding the next instruction is bypassed with no lost cycle. A load feeding the next instruction costs exactly one bubble, and after that bubble its value comes from the memory-to-write-back latch. Register zero always reads as 0, so a dependency on it never forwards and never stalls.

The register file is assumed to return a value written in the same cycle. The block is purely combinational, and all sizes are parameters.

Top module: `hz_bypass_unit`

## Requirements
- R1: An execute operand whose index matches no eligible older destination selects the register file, code 2'b00.
- R2: An execute operand equal to the execute/memory latch destination, with that latch's write enable high, selects code 2'b10.
- R3: An execute operand equal to the memory/write-back latch destination, with that latch's write enable high, selects code 2'b01.
- R4: When both latches match the same operand, the younger execute/memory value (2'b10) is chosen.
- R5: A latch whose write enable is low never supplies a bypass, even if its destination index matches.
- R6: Register index 0 never causes a bypass and never causes an interlock.
- R7: The interlock is high when the decode/execute latch holds a load with write enable high and a non-zero destination equal to either decode source.
- R8: A non-load producer in the decode/execute latch never raises the interlock, so an ALU-to-ALU dependency costs zero cycles.
- R9: Each execute operand's select is decided independently of the other operand's index.
- R10: In a running pipeline, a load followed directly by a consumer loses exactly one cycle. The consumer then takes the loaded value from the memory/write-back latch (2'b01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src | input | NUM_SRC*IDX_W | Source indices of the instruction in decode |
| exe_src | input | NUM_SRC*IDX_W | Source indices of the instruction in execute |
| idex_dst | input | IDX_W | Destination of the instruction in the decode/execute latch |
| idex_wen | input | 1 | Register write enable of that instruction |
| idex_is_load | input | 1 | That instruction is a load |
| exm_dst | input | IDX_W | Destination held in the execute/memory latch |
| exm_wen | input | 1 | Write enable held in the execute/memory latch |
| mwb_dst | input | IDX_W | Destination held in the memory/write-back latch |
| mwb_wen | input | 1 | Write enable held in the memory/write-back latch |
| byp_sel | output | NUM_SRC*2 | Per-operand bypass select: 00 register file, 10 execute/memory, 01 memory/write-back |
| stall | output | 1 | Hold PC and fetch/decode latch, insert a bubble into decode/execute |

## Verification
The bench is built with 3-bit register indices. It sweeps every combination of operand index, both latch destinations and both write enables. This separates a plain match from a match that is gated off by a low write enable, a match on register zero, and a double match that must resolve to the younger stage. The second operand carries a shifted index, so that cross-talk between the operands shows up. A second sweep covers every decode source pair against every decode/execute destination with every load and write-enable setting. It tells a true load-use case apart from an ALU producer, a disabled write and a zero destination. A short pipeline model then runs a load, two dependent ALU operations and a load to register zero, and checks where the bubble falls and which select each consumer receives.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    BYP_RF    = 2'b00,
    BYP_MWB   = 2'b01,
    BYP_EXM   = 2'b10
  } byp_sel_e;
endpackage

// File: rtl/hz_idx_match.sv
module hz_idx_match #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] src,
  input  logic [IDX_W-1:0] dst,
  input  logic             wen,
  output logic             hit
);
  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  always_comb begin
    hit = wen && (dst != ZERO_IDX) && (src == dst);
  end
endmodule

// File: rtl/hz_bypass_pick.sv
module hz_bypass_pick
  import hz_pkg::*;
(
  input  logic     hit_near,
  input  logic     hit_far,
  output byp_sel_e sel
);
  always_comb begin
    if (hit_near)     sel = BYP_EXM;
    else if (hit_far) sel = BYP_MWB;
    else              sel = BYP_RF;
  end

  always_comb begin
    assert_sel_code_legal_R1: assert (sel != byp_sel_e'(2'b11))
      else $error("illegal bypass code");
  end
endmodule

// File: rtl/hz_loaduse_detect.sv
module hz_loaduse_detect #(
  parameter int IDX_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][IDX_W-1:0] dec_src,
  input  logic [IDX_W-1:0]              prod_dst,
  input  logic                          prod_wen,
  input  logic                          prod_load,
  output logic                          stall
);
  logic [NUM_SRC-1:0] src_hit;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_cmp
    hz_idx_match #(.IDX_W(IDX_W)) u_cmp (
      .src (dec_src[k]),
      .dst (prod_dst),
      .wen (prod_wen),
      .hit (src_hit[k])
    );
  end

  always_comb begin
    stall = prod_load && (|src_hit);
  end
endmodule

// File: rtl/hz_bypass_unit.sv
module hz_bypass_unit
  import hz_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][IDX_W-1:0] dec_src,
  input  logic [NUM_SRC-1:0][IDX_W-1:0] exe_src,
  input  logic [IDX_W-1:0]              idex_dst,
  input  logic                          idex_wen,
  input  logic                          idex_is_load,
  input  logic [IDX_W-1:0]              exm_dst,
  input  logic                          exm_wen,
  input  logic [IDX_W-1:0]              mwb_dst,
  input  logic                          mwb_wen,
  output logic [NUM_SRC-1:0][1:0]       byp_sel,
  output logic                          stall
);
  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic [NUM_SRC-1:0] hit_exm;
  logic [NUM_SRC-1:0] hit_mwb;
  byp_sel_e           sel_e [NUM_SRC];

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_opnd
    hz_idx_match #(.IDX_W(IDX_W)) u_near (
      .src (exe_src[k]), .dst (exm_dst), .wen (exm_wen), .hit (hit_exm[k])
    );
    hz_idx_match #(.IDX_W(IDX_W)) u_far (
      .src (exe_src[k]), .dst (mwb_dst), .wen (mwb_wen), .hit (hit_mwb[k])
    );
    hz_bypass_pick u_pick (
      .hit_near (hit_exm[k]),
      .hit_far  (hit_mwb[k]),
      .sel      (sel_e[k])
    );
    assign byp_sel[k] = sel_e[k];
  end

  hz_loaduse_detect #(.IDX_W(IDX_W), .NUM_SRC(NUM_SRC)) u_lu (
    .dec_src   (dec_src),
    .prod_dst  (idex_dst),
    .prod_wen  (idex_wen),
    .prod_load (idex_is_load),
    .stall     (stall)
  );

  always_comb begin
    for (int k = 0; k < NUM_SRC; k++) begin
      assert_zero_reg_rf_R6: assert (exe_src[k] != ZERO_IDX || byp_sel[k] == 2'b00)
        else $error("register zero bypassed");
      assert_near_needs_wen_R5: assert (byp_sel[k] != 2'b10 || (exm_wen && exm_dst == exe_src[k]))
        else $error("bypass from disabled or unmatched EX/MEM");
      assert_far_needs_wen_R5: assert (byp_sel[k] != 2'b01 || (mwb_wen && mwb_dst == exe_src[k]))
        else $error("bypass from disabled or unmatched MEM/WB");
      assert_younger_wins_R4: assert (!(exm_wen && exm_dst == exe_src[k] && exe_src[k] != ZERO_IDX)
                                      || byp_sel[k] == 2'b10)
        else $error("younger stage not preferred");
    end
    assert_stall_only_load_R7: assert (!stall || (idex_is_load && idex_wen && idex_dst != ZERO_IDX))
      else $error("stall without a load producer");
  end
endmodule

// File: tb/hz_bypass_unit_test.sv
module hz_bypass_unit_test;
  localparam int W = 3;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NS-1:0][W-1:0] dec_src, exe_src;
  logic [W-1:0] idex_dst, exm_dst, mwb_dst;
  logic idex_wen, idex_is_load, exm_wen, mwb_wen;
  logic [NS-1:0][1:0] byp_sel;
  logic stall;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  hz_bypass_unit #(.IDX_W(W), .NUM_SRC(NS)) uut (
    .dec_src(dec_src), .exe_src(exe_src),
    .idex_dst(idex_dst), .idex_wen(idex_wen), .idex_is_load(idex_is_load),
    .exm_dst(exm_dst), .exm_wen(exm_wen),
    .mwb_dst(mwb_dst), .mwb_wen(mwb_wen),
    .byp_sel(byp_sel), .stall(stall)
  );

  function automatic logic [1:0] exp_sel(logic [W-1:0] s, logic [W-1:0] nd, logic nw,
                                         logic [W-1:0] fd, logic fw);
    if (s != 0 && nw && nd == s) return 2'b10;
    if (s != 0 && fw && fd == s) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0] tag;
    logic [W-1:0] dst, s0, s1;
    logic wen, ld;
  } ins_t;
  localparam ins_t BUB = '{tag: 4'hF, dst: '0, s0: '0, s1: '0, wen: 1'b0, ld: 1'b0};

  initial begin
    #200_000_0;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    dec_src = '0; exe_src = '0; idex_dst = '0; idex_wen = 0; idex_is_load = 0;
    exm_dst = '0; exm_wen = 0; mwb_dst = '0; mwb_wen = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 reset sel0", {2'b0, byp_sel[0]}, 4'h0);
    chk("R1 reset sel1", {2'b0, byp_sel[1]}, 4'h0);
    chk("R6 reset stall", {3'b0, stall}, 4'h0);

    // Bypass sweep: R1 R2 R3 R4 R5 R6 R9
    for (int s = 0; s < 8; s++)
      for (int nd = 0; nd < 8; nd++)
        for (int nw = 0; nw < 2; nw++)
          for (int fd = 0; fd < 8; fd++)
            for (int fw = 0; fw < 2; fw++) begin
              @(negedge clk);
              exe_src[0] = W'(s);
              exe_src[1] = W'((s + 3) % 8);
              exm_dst = W'(nd); exm_wen = nw[0];
              mwb_dst = W'(fd); mwb_wen = fw[0];
              #1;
              chk("R2_R3_R4_R5_R6 op0", {2'b0, byp_sel[0]},
                  {2'b0, exp_sel(W'(s), W'(nd), nw[0], W'(fd), fw[0])});
              chk("R9 op1", {2'b0, byp_sel[1]},
                  {2'b0, exp_sel(W'((s + 3) % 8), W'(nd), nw[0], W'(fd), fw[0])});
            end
    exe_src = '0; exm_wen = 0; mwb_wen = 0;

    // Load-use sweep: R6 R7 R8
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int d = 0; d < 8; d++)
          for (int m = 0; m < 4; m++) begin
            logic e;
            @(negedge clk);
            dec_src[0] = W'(a); dec_src[1] = W'(b);
            idex_dst = W'(d); idex_wen = m[0]; idex_is_load = m[1];
            e = m[0] && m[1] && d != 0 && (a == d || b == d);
            #1;
            chk("R7_R8_R6 stall", {3'b0, stall}, {3'b0, e});
          end

    // Pipeline skeleton: R10
    begin
      ins_t prog [8];
      ins_t ifid, idex, exm, mwb;
      int pc, stalls, steps;
      prog[0] = '{tag: 4'd0, dst: 3'd1, s0: 3'd5, s1: 3'd0, wen: 1'b1, ld: 1'b1};
      prog[1] = '{tag: 4'd1, dst: 3'd2, s0: 3'd1, s1: 3'd3, wen: 1'b1, ld: 1'b0};
      prog[2] = '{tag: 4'd2, dst: 3'd4, s0: 3'd2, s1: 3'd2, wen: 1'b1, ld: 1'b0};
      prog[3] = '{tag: 4'd3, dst: 3'd0, s0: 3'd6, s1: 3'd0, wen: 1'b1, ld: 1'b1};
      prog[4] = '{tag: 4'd4, dst: 3'd5, s0: 3'd0, s1: 3'd0, wen: 1'b1, ld: 1'b0};
      for (int i = 5; i < 8; i++) prog[i] = '{tag: 4'(i), dst: '0, s0: '0, s1: '0, wen: 1'b0, ld: 1'b0};
      ifid = BUB; idex = BUB; exm = BUB; mwb = BUB;
      pc = 0; stalls = 0; steps = 0;
      while (idex.tag != 4'd4 && steps < 30) begin
        @(negedge clk);
        dec_src[0] = ifid.s0; dec_src[1] = ifid.s1;
        exe_src[0] = idex.s0; exe_src[1] = idex.s1;
        idex_dst = idex.dst; idex_wen = idex.wen; idex_is_load = idex.ld;
        exm_dst = exm.dst; exm_wen = exm.wen;
        mwb_dst = mwb.dst; mwb_wen = mwb.wen;
        #1;
        if (stall) stalls++;
        if (idex.tag == 4'd1) begin
          chk("R10 load value from MEM/WB", {2'b0, byp_sel[0]}, 4'h1);
          chk("R10 other operand from RF", {2'b0, byp_sel[1]}, 4'h0);
          chk("R10 bubble ahead of consumer", {exm.tag}, 4'hF);
        end
        if (idex.tag == 4'd2) begin
          chk("R10 ALU chain sel0", {2'b0, byp_sel[0]}, 4'h2);
          chk("R10 ALU chain sel1", {2'b0, byp_sel[1]}, 4'h2);
        end
        mwb = exm; exm = idex;
        if (stall) idex = BUB;
        else begin
          idex = ifid; ifid = prog[pc]; pc++;
        end
        steps++;
      end
      chk("R10 consumer of r0 reached EX", idex.tag, 4'd4);
      #0;
      chk("R10 total bubbles", 4'(stalls), 4'd1);
      chk("R10 cycle count", 4'(steps), 4'd7);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule